// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This controller sits on the host side of a byte-wide parallel EEPROM. It writes one burst of bytes into a single device page. A one-cycle start command carries a base address and a byte count. The sequencer first checks that the burst fits inside the page the base address selects. If it does, it pulls bytes from a ready/valid stream. For each byte it drives the address and data buses and then produces a chip-select and write-strobe pulse. The strobe low time, the strobe high time, and the data setup and hold times all meet the device minimums. Every one of these times is given in nanoseconds and turned into clock cycles when the design elaborates.

The device latches the bytes into a page buffer. It starts committing that buffer when no new byte arrives within its load window. The sequencer therefore limits how long it waits for the next byte. If the stream stalls past that limit, the burst is cut short and reported as an error. After the last strobe, or after a cut-short burst, the block stays busy for the full worst-case commit time and then pulses done. Only the in-page offset bits of the address advance from byte to byte. The output-enable line is never asserted.

Top module: `eeprom_page_writer`

## Requirements
- R1: While reset is low and in the cycle after it, ee_we_n, ee_cs_n and ee_oe_n are 1, and ee_dq_oe, in_ready, busy, done and err are 0.
- R2: ee_oe_n is 1 in every cycle.
- R3: A start in idle with byte_cnt of 0, or with base_addr[PAGE_BITS-1:0] + byte_cnt greater than 2**PAGE_BITS, raises err for exactly the next cycle. It produces no strobe and leaves busy at 0.
- R4: Each byte has three phases in which ee_cs_n is 0: setup for ADDR_SU_CYC cycles (ee_we_n 1), strobe for max(ceil(WP_NS/CLK_NS), ceil(DS_NS/CLK_NS)) cycles (ee_we_n 0), and hold for max(ceil(WPH_NS/CLK_NS), ceil(DH_NS/CLK_NS)) cycles (ee_we_n 1).
- R5: Between two strobes of one burst, ee_we_n stays 1 for at least the hold length plus the setup length.
- R6: ee_dq_oe is 1 exactly while ee_cs_n is 0. During that time ee_dq holds the byte accepted for that access.
- R7: While ee_cs_n is 0 for the k-th byte (k from 0), the bits of ee_addr above PAGE_BITS equal those of base_addr, and the lower PAGE_BITS bits equal (base offset + k) mod 2**PAGE_BITS.
- R8: in_ready is 1 only while the block waits for a byte. A byte is accepted in a cycle where both in_valid and in_ready are 1. Without in_valid, the block waits and produces no strobe.
- R9: If the block waits for GAP = floor(LOAD_WIN_NS/CLK_NS) − setup − strobe − hold − 1 cycles in a row without a byte, err is 1 for one cycle and the burst ends with the program wait. A wait of fewer cycles has no effect.
- R10: After the hold phase of the last byte (or after a timeout), busy stays 1 for ceil(PROG_NS/CLK_NS) cycles. Then done is 1 for one cycle and busy returns to 0.
- R11: A start that arrives while busy is 1 is ignored.
- R12: An accepted request produces exactly byte_cnt strobes, unless a timeout ends it early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to write a burst |
| base_addr | input | ADDR_W | Device address of the first byte |
| byte_cnt | input | PAGE_BITS+1 | Number of bytes in the burst |
| busy | output | 1 | A burst or its program wait is in progress |
| done | output | 1 | One-cycle pulse when the program wait ends |
| err | output | 1 | One-cycle pulse for a rejected request or a stalled stream |
| in_valid | input | 1 | Stream byte is present |
| in_data | input | DATA_W | Stream byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| ee_addr | output | ADDR_W | Device address bus |
| ee_dq | output | DATA_W | Device data bus value |
| ee_dq_oe | output | 1 | Data bus driver enable |
| ee_cs_n | output | 1 | Device chip select, active low |
| ee_we_n | output | 1 | Device write strobe, active low |
| ee_oe_n | output | 1 | Device output enable, active low (held high) |

## Verification
Suppose the phase state or its shared timer goes wrong. The strobe, chip-select or ready line then leaves the expected per-cycle pattern in that same cycle, and a wrong-length phase shows up at the next edge of ee_we_n. A wrong remaining-byte count appears only at the end of the burst, as an extra strobe or a missing one and a done pulse in the wrong cycle. A bad offset register shows up on ee_addr at the very next select window. Because the bench compares every output on every cycle, each of these faults is caught within one cycle of becoming visible.

// File: rtl/epw_pkg.sv
package epw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_PROG
   } epw_state_e;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/epw_timer.sv
module epw_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/epw_req_check.sv
module epw_req_check #(
   parameter int PAGE_BITS = 7,
   localparam int CNT_W    = PAGE_BITS + 1
) (
   input  logic [PAGE_BITS-1:0] offset,
   input  logic [CNT_W-1:0]     count,
   output logic                 fits
);
   localparam logic [CNT_W:0] PAGE_SZ = (CNT_W+1)'(2 ** PAGE_BITS);
   logic [CNT_W:0] end_pos;

   assign end_pos = {2'b00, offset} + {1'b0, count};
   assign fits    = (count != '0) && (end_pos <= PAGE_SZ);
endmodule

// File: rtl/epw_addr_gen.sv
module epw_addr_gen #(
   parameter int ADDR_W    = 19,
   parameter int PAGE_BITS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   logic [PAGE_BITS-1:0] off_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     off_q <= '0;
      else if (load)  off_q <= base[PAGE_BITS-1:0];
      else if (step)  off_q <= off_q + 1'b1;
   end

   generate
      if (ADDR_W > PAGE_BITS) begin : g_split
         logic [ADDR_W-PAGE_BITS-1:0] page_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    page_q <= '0;
            else if (load) page_q <= base[ADDR_W-1:PAGE_BITS];
         end
         assign addr = {page_q, off_q};
      end else begin : g_flat
         assign addr = off_q;
      end
   endgenerate
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
   import epw_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int PAGE_BITS   = 7,
   parameter int DATA_W      = 8,
   parameter int CLK_NS      = 20,
   parameter int WP_NS       = 150,
   parameter int WPH_NS      = 50,
   parameter int DS_NS       = 100,
   parameter int DH_NS       = 10,
   parameter int ADDR_SU_CYC = 1,
   parameter int LOAD_WIN_NS = 150000,
   parameter int PROG_NS     = 10000000,
   localparam int CNT_W      = PAGE_BITS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [CNT_W-1:0]  byte_cnt,
   output logic              busy,
   output logic              done,
   output logic              err,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic [ADDR_W-1:0] ee_addr,
   output logic [DATA_W-1:0] ee_dq,
   output logic              ee_dq_oe,
   output logic              ee_cs_n,
   output logic              ee_we_n,
   output logic              ee_oe_n
);
   localparam int LO_CYC   = max2(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(DS_NS, CLK_NS));
   localparam int HI_CYC   = max2(max2(ns_to_cyc(WPH_NS, CLK_NS), ns_to_cyc(DH_NS, CLK_NS)), 1);
   localparam int SU_CYC   = ADDR_SU_CYC;
   localparam int GAP_CYC  = LOAD_WIN_NS / CLK_NS - SU_CYC - LO_CYC - HI_CYC - 1;
   localparam int PROG_CYC = ns_to_cyc(PROG_NS, CLK_NS);
   localparam int TMR_MAX  = max2(max2(PROG_CYC, GAP_CYC), max2(LO_CYC, HI_CYC));
   localparam int TMR_W    = $clog2(TMR_MAX + 1);

   initial begin
      assert (PAGE_BITS >= 1 && PAGE_BITS <= ADDR_W) else $error("PAGE_BITS out of range");
      assert (ADDR_SU_CYC >= 1) else $error("ADDR_SU_CYC must be at least 1");
      assert (GAP_CYC >= 1) else $error("load window too short for one strobe");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   epw_state_e        st_q, st_d;
   logic [CNT_W-1:0]  left_q, left_d;
   logic [DATA_W-1:0] data_q;
   logic              err_q, err_d, done_q, done_d;
   logic              tmr_ld, tmr_exp, addr_ld, step, acc, req_ok;
   logic [TMR_W-1:0]  tmr_val;

   epw_req_check #(.PAGE_BITS(PAGE_BITS)) u_chk (
      .offset(base_addr[PAGE_BITS-1:0]), .count(byte_cnt), .fits(req_ok));

   epw_timer #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_exp));

   epw_addr_gen #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(addr_ld), .base(base_addr), .step(step), .addr(ee_addr));

   always_comb begin
      st_d    = st_q;
      left_d  = left_q;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      addr_ld = 1'b0;
      step    = 1'b0;
      acc     = 1'b0;
      err_d   = 1'b0;
      done_d  = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start) begin
            if (req_ok) begin
               st_d    = ST_WAIT;
               left_d  = byte_cnt;
               addr_ld = 1'b1;
               tmr_ld  = 1'b1;
               tmr_val = TMR_W'(GAP_CYC - 1);
            end else begin
               err_d = 1'b1;
            end
         end
         ST_WAIT: if (in_valid) begin
            acc     = 1'b1;
            st_d    = ST_SETUP;
            tmr_ld  = 1'b1;
            tmr_val = TMR_W'(SU_CYC - 1);
         end else if (tmr_exp) begin
            err_d   = 1'b1;
            st_d    = ST_PROG;
            tmr_ld  = 1'b1;
            tmr_val = TMR_W'(PROG_CYC - 1);
         end
         ST_SETUP: if (tmr_exp) begin
            st_d    = ST_LOW;
            tmr_ld  = 1'b1;
            tmr_val = TMR_W'(LO_CYC - 1);
         end
         ST_LOW: if (tmr_exp) begin
            st_d    = ST_HIGH;
            tmr_ld  = 1'b1;
            tmr_val = TMR_W'(HI_CYC - 1);
         end
         ST_HIGH: if (tmr_exp) begin
            step   = 1'b1;
            left_d = left_q - 1'b1;
            tmr_ld = 1'b1;
            if (left_q == CNT_W'(1)) begin
               st_d    = ST_PROG;
               tmr_val = TMR_W'(PROG_CYC - 1);
            end else begin
               st_d    = ST_WAIT;
               tmr_val = TMR_W'(GAP_CYC - 1);
            end
         end
         ST_PROG: if (tmr_exp) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         left_q <= '0;
         data_q <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         left_q <= left_d;
         err_q  <= err_d;
         done_q <= done_d;
         if (acc) data_q <= in_data;
      end
   end

   assign busy     = (st_q != ST_IDLE);
   assign done     = done_q;
   assign err      = err_q;
   assign in_ready = (st_q == ST_WAIT);
   assign ee_cs_n  = !(st_q == ST_SETUP || st_q == ST_LOW || st_q == ST_HIGH);
   assign ee_we_n  = (st_q != ST_LOW);
   assign ee_dq_oe = !ee_cs_n;
   assign ee_dq    = data_q;
   assign ee_oe_n  = 1'b1;

   // Pulse-width monitors feeding the timing assertions
   logic [TMR_W-1:0] mon_lo_q, mon_hi_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mon_lo_q <= '0;
         mon_hi_q <= '1;
      end else begin
         mon_lo_q <= ee_we_n ? '0 : mon_lo_q + 1'b1;
         mon_hi_q <= !ee_we_n ? '0 : ((mon_hi_q == '1) ? mon_hi_q : mon_hi_q + 1'b1);
      end
   end

   AST_STROBE_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_we_n) |-> mon_lo_q == TMR_W'(LO_CYC)); // R4
   AST_STROBE_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_we_n) |-> mon_hi_q >= TMR_W'(SU_CYC + HI_CYC)); // R5
   AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (!ee_cs_n && $past(!ee_cs_n)) |-> $stable(ee_dq)); // R6
   AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (!ee_cs_n && $past(!ee_cs_n)) |-> $stable(ee_addr)); // R7
   AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ee_we_n && ee_cs_n)); // R3
   AST_READY_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> ee_cs_n); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy)); // R10
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> !err || $past(in_ready)); // R11
endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
   localparam int AW = 19, PB = 7, DW = 8, CLK_NS = 20;
   localparam int LOAD_NS = 2000, PROG_NS = 2000;

   function automatic int up(input int ns);
      return (ns + CLK_NS - 1) / CLK_NS;
   endfunction
   localparam int E_SU   = 1;
   localparam int E_LO   = (up(150) > up(100)) ? up(150) : up(100);
   localparam int E_HI   = (up(50) > up(10)) ? up(50) : up(10);
   localparam int E_GAP  = LOAD_NS / CLK_NS - E_SU - E_LO - E_HI - 1;
   localparam int E_PROG = up(PROG_NS);

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [PB:0]   byte_cnt = '0;
   logic [DW-1:0] in_data = '0;
   logic busy, done, err, in_ready, ee_dq_oe, ee_cs_n, ee_we_n, ee_oe_n;
   logic [AW-1:0] ee_addr;
   logic [DW-1:0] ee_dq;

   always #10 clk = ~clk;

   eeprom_page_writer #(.ADDR_W(AW), .PAGE_BITS(PB), .DATA_W(DW), .CLK_NS(CLK_NS),
      .LOAD_WIN_NS(LOAD_NS), .PROG_NS(PROG_NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .byte_cnt(byte_cnt),
      .busy(busy), .done(done), .err(err), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .ee_addr(ee_addr), .ee_dq(ee_dq), .ee_dq_oe(ee_dq_oe),
      .ee_cs_n(ee_cs_n), .ee_we_n(ee_we_n), .ee_oe_n(ee_oe_n));

   int tests = 0, fails = 0;
   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // stream source
   logic [DW-1:0] dq_q[$];
   int pre_q[$];
   bit popped = 0;
   always @(negedge clk) begin
      if (popped) begin
         void'(dq_q.pop_front());
         void'(pre_q.pop_front());
         popped = 0;
      end
      if (dq_q.size() > 0) begin
         if (pre_q[0] > 0) begin
            pre_q[0]--;
            in_valid = 0;
         end else begin
            in_valid = 1;
            in_data  = dq_q[0];
         end
      end else in_valid = 0;
   end

   // behavioural reference: phase 0 idle,1 wait,2 setup,3 strobe,4 hold,5 program
   int m_ph = 0, m_n = 0, m_left = 0;
   bit m_err = 0, m_done = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_dat = '0;
   always @(posedge clk) begin
      m_err = 0; m_done = 0;
      if (!rst_n) m_ph = 0;
      else case (m_ph)
         0: if (start) begin
               if (byte_cnt == 0 || int'(base_addr[PB-1:0]) + int'(byte_cnt) > 128) m_err = 1;
               else begin m_ph = 1; m_n = 0; m_left = byte_cnt; m_addr = base_addr; end
            end
         1: if (in_valid) begin m_dat = in_data; popped = 1; m_ph = 2; m_n = 0; end
            else if (m_n == E_GAP - 1) begin m_err = 1; m_ph = 5; m_n = 0; end
            else m_n++;
         2: begin m_n++; if (m_n == E_SU) begin m_ph = 3; m_n = 0; end end
         3: begin m_n++; if (m_n == E_LO) begin m_ph = 4; m_n = 0; end end
         4: begin
               m_n++;
               if (m_n == E_HI) begin
                  m_n = 0; m_left--;
                  m_addr[PB-1:0] = m_addr[PB-1:0] + 1'b1;
                  m_ph = (m_left == 0) ? 5 : 1;
               end
            end
         5: begin m_n++; if (m_n == E_PROG) begin m_ph = 0; m_done = 1; end end
         default: m_ph = 0;
      endcase
   end

   // per-cycle comparison and strobe monitor
   int strobes = 0, lo_run = 0, hi_run = 0;
   bit prev_we = 1, seen_rise = 0;
   always @(negedge clk) if (rst_n) begin
      bit m_cs_n;
      m_cs_n = !(m_ph >= 2 && m_ph <= 4);
      chk(ee_we_n == (m_ph != 3), "R4 we_n", ee_we_n, m_ph != 3);
      chk(ee_cs_n == m_cs_n, "R4 cs_n", ee_cs_n, m_cs_n);
      chk(ee_oe_n == 1'b1, "R2 oe_n", ee_oe_n, 1);
      chk(ee_dq_oe == !m_cs_n, "R6 dq_oe", ee_dq_oe, !m_cs_n);
      chk(in_ready == (m_ph == 1), "R8 in_ready", in_ready, m_ph == 1);
      chk(busy == (m_ph != 0), "R10 busy", busy, m_ph != 0);
      chk(done == m_done, "R10 done", done, m_done);
      chk(err == m_err, "R3 R9 err", err, m_err);
      if (!m_cs_n) begin
         chk(ee_addr == m_addr, "R7 addr", ee_addr, m_addr);
         chk(ee_dq == m_dat, "R6 data", ee_dq, m_dat);
      end
      if (prev_we && !ee_we_n) begin
         strobes++;
         if (seen_rise) chk(hi_run >= E_SU + E_HI, "R5 high gap", hi_run, E_SU + E_HI);
         lo_run = 0;
      end
      if (!prev_we && ee_we_n) begin
         chk(lo_run == E_LO, "R4 low width", lo_run, E_LO);
         seen_rise = 1; hi_run = 0;
      end
      if (!ee_we_n) lo_run++; else hi_run++;
      prev_we = ee_we_n;
   end

   task automatic push(input int n, input int seed, input int stall_at, input int stall_len);
      for (int i = 0; i < n; i++) begin
         dq_q.push_back(DW'(seed + i * 37));
         pre_q.push_back(i == stall_at ? stall_len : 0);
      end
   endtask

   task automatic run(input logic [AW-1:0] b, input int c, input int exp_strb,
                      input bit poke, input string tag);
      @(negedge clk);
      strobes = 0; seen_rise = 0;
      start = 1; base_addr = b; byte_cnt = (PB+1)'(c);
      @(negedge clk);
      start = 0;
      if (poke) begin
         repeat (4) @(negedge clk);
         start = 1; byte_cnt = 0;           // R11: must be ignored while busy
         @(negedge clk);
         start = 0;
      end
      while (m_ph != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(strobes == exp_strb, tag, strobes, exp_strb);
      dq_q.delete(); pre_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(ee_we_n && ee_cs_n && ee_oe_n && !ee_dq_oe && !in_ready && !busy && !done && !err,
          "R1 reset outputs", {ee_we_n, ee_cs_n, ee_oe_n, ee_dq_oe, in_ready, busy}, 6'b111000);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && ee_we_n && !err, "R1 after reset", busy, 0);
      push(3, 8'h11, -1, 0);
      run({12'h155, 7'd5}, 3, 3, 0, "R12 short burst");
      run({12'h0A0, 7'd3}, 0, 0, 0, "R3 zero count");
      push(30, 8'h40, -1, 0);
      run({12'h0A0, 7'd100}, 30, 0, 0, "R3 crosses page");
      push(8, 8'h80, 2, 20);
      run({12'h7FF, 7'd120}, 8, 8, 0, "R12 R8 last bytes with stall");
      push(128, 8'h03, 60, E_GAP - 5);
      run({12'h321, 7'd0}, 128, 128, 0, "R12 R9 full page, long stall");
      push(2, 8'hC0, -1, 0);
      run({12'h010, 7'd40}, 4, 2, 0, "R9 timeout truncates");
      push(2, 8'h5A, -1, 0);
      run({12'h222, 7'd127}, 1, 1, 1, "R11 start while busy");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule